// File: doc/BRIEF.md
# Inclusive L2 Line Coherence Controller

This block holds the coherence state of one line in a shared, inclusive second-level cache. Several private first-level caches sit in front of it. Each cycle it can take one decoded event: an L1 request, an L1 writeback, a memory reply, an L1 data or unblock reply, a replacement trigger or an external invalidate. In the same cycle it raises the message strobes that the event calls for: a fetch to memory, a forward to the owning L1, an invalidate to a set of L1s, data to a set of L1s, an ack, a writeback ack, or a write-back to memory. A recycle strobe tells the upstream queue to offer the same request again later.

The line tracks a sharer bit-vector, the ID of the L1 that holds it modified, the set of readers waiting for a fill, the ID of a pending writer, and a dirty flag. Data storage, the network and the victim choice are handled elsewhere. Messages are reduced to their kind, a destination mask or ID, and a grant flag. There are four stable states: not present, shared, modified in the L2 only, and modified in one L1 with a stale L2 copy. There are also fill, blocking, forwarding and eviction transient states.

Top module: `l2_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0, `sharers` and `owner` are 0 and every strobe is low. While `ev_valid` is low, all strobes stay low and the state does not change. State codes: 0 not present, 1 shared, 2 modified in L2, 3 modified in an L1, 4 single-reader fill, 5 multi-reader fill, 6 writer fill, 7 awaiting exclusive unblock, 8 forwarded awaiting unblock and data, 9 forwarded awaiting data, 10 forwarded awaiting unblock, 11 evicting awaiting memory ack.
- R2: Event codes on `ev_kind`: 0 read, 1 instruction read, 2 write, 3 upgrade, 4 writeback, 5 memory data, 6 memory ack, 7 L1 data, 8 unblock, 9 exclusive unblock, 10 replace, 11 external invalidate. Codes 12 to 15 raise no strobe and change nothing. Strobes respond in the cycle of the event. The new state is visible after the next rising clock edge.
- R3: A read in state 0 raises `send_fetch`, sets sharers to the requester only, and moves to state 4. Memory data in state 4 sends data to that reader with `data_excl`=1 and moves to state 7.
- R4: An instruction read in state 0 fetches and moves to state 5. A read or instruction read in state 4 or 5 adds the requester to the readers and the sharers, goes to state 5, and is not recycled. Memory data in state 5 sends data with `data_excl`=0 to every recorded reader and moves to state 1.
- R5: A write in state 0 fetches, clears the sharers, records the writer and moves to state 6. An upgrade from a non-sharer counts as a write in every state. Memory data in state 6 sends exclusive data to the recorded writer only and moves to state 7.
- R6: In state 1, a read or instruction read sends shared data to the requester and adds it as a sharer. A write sends exclusive data to the requester. An upgrade from a sharer sends `send_ack` and no data. Both a write and such an upgrade invalidate the sharers other than the requester (`send_inv` only when that set is non-empty) and move to state 7.
- R7: An exclusive unblock in state 7 sets the sharers to the sender only, makes the sender the owner, and moves to state 3.
- R8: In state 3, a read or instruction read raises `send_fwd` with `fwd_dst` equal to the owner and moves to state 8. A write or upgrade is forwarded and moves to state 7. In state 8, an unblock adds the sender as a sharer and moves to 9, and L1 data moves to 10. The other reply then completes the move to state 1.
- R9: In states 4 to 11, requests (codes 0 to 3), replace and external invalidate raise `recycle` alone and change nothing. The exceptions are the read merge of R4 and an external invalidate in state 11, which is dropped without recycle.
- R10: Every writeback raises `send_wback_ack`. A writeback from the owner in state 3 clears the sharers, takes its dirty flag from `ev_dirty`, and moves to state 2. Any other writeback changes nothing.
- R11: Replace in state 2 raises `send_mem_data` if the line is dirty, otherwise `send_mem_ack`, and moves to state 11. Memory ack in state 11 returns to state 0 with the sharers cleared.
- R12: In state 2, a read sends exclusive data to the requester and moves to 7. An instruction read sends shared data, sets the sharers to the requester and moves to 1. A write or upgrade sends exclusive data and moves to 7.
- R13: Events that a stable state does not handle (replace in states 0, 1 and 3, external invalidate, memory or L1 replies) raise no strobe other than the writeback ack and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 4 | Event code (see R2) |
| ev_src | input | IDW | L1 ID of the event's sender or requester |
| ev_dirty | input | 1 | Dirty flag carried by a writeback |
| recycle | output | 1 | Retry this event later |
| send_fetch | output | 1 | Issue a fetch to memory |
| send_fwd | output | 1 | Forward the request to the owning L1 |
| fwd_dst | output | IDW | Destination of the forward |
| send_inv | output | 1 | Send invalidates |
| inv_mask | output | NUM_L1 | Invalidate destinations |
| send_data | output | 1 | Send line data to L1s |
| data_mask | output | NUM_L1 | Data destinations |
| data_excl | output | 1 | Data grants exclusive permission |
| send_ack | output | 1 | Ack to the upgrading requester |
| send_wback_ack | output | 1 | Ack to the writeback sender |
| send_mem_data | output | 1 | Write dirty data back to memory |
| send_mem_ack | output | 1 | Clean-eviction notice to memory |
| line_state | output | 4 | Current state code |
| sharers | output | NUM_L1 | Sharer bit-vector |
| owner | output | IDW | Exclusive owner ID |

## Verification
The bench drives both orders of the forward replies. A design that needs the unblock before the data would hang in state 8 or drop the new sharer. It sends a second read during a single-reader fill; getting that wrong would either recycle the read or grant exclusive data to two L1s. It sends an upgrade from an L1 that is no longer a sharer, which must be served with data like a write, and a writeback from a stale L1 while another L1 owns the line, which must be acked without taking ownership away. Eviction is exercised both clean and dirty, and an invalidate that arrives while the eviction is in flight must be dropped rather than recycled forever.

// File: rtl/l2c_pkg.sv
package l2c_pkg;

  typedef enum logic [3:0] {
    EV_READ   = 4'd0,
    EV_IREAD  = 4'd1,
    EV_WRITE  = 4'd2,
    EV_UPGR   = 4'd3,
    EV_WBACK  = 4'd4,
    EV_MDATA  = 4'd5,
    EV_MACK   = 4'd6,
    EV_LDATA  = 4'd7,
    EV_UNBLK  = 4'd8,
    EV_XUNBLK = 4'd9,
    EV_REPL   = 4'd10,
    EV_MINV   = 4'd11
  } ev_kind_e;

  typedef enum logic [3:0] {
    LS_IDLE   = 4'd0,
    LS_SHR    = 4'd1,
    LS_MOD    = 4'd2,
    LS_L1OWN  = 4'd3,
    LS_FILL1  = 4'd4,
    LS_FILLN  = 4'd5,
    LS_FILLW  = 4'd6,
    LS_WAITX  = 4'd7,
    LS_FWD2   = 4'd8,
    LS_FWDD   = 4'd9,
    LS_FWDU   = 4'd10,
    LS_EVICT  = 4'd11
  } line_st_e;

  typedef struct packed {
    logic rd;
    logic ird;
    logic wr;
    logic upg;
    logic wb;
    logic mdata;
    logic mack;
    logic ldata;
    logic unb;
    logic xunb;
    logic repl;
    logic minv;
  } ev_flags_t;

  typedef struct packed {
    logic recycle;
    logic fetch;
    logic fwd;
    logic inv;
    logic data;
    logic excl;
    logic ack;
    logic wback_ack;
    logic mem_data;
    logic mem_ack;
  } strobe_t;

  function automatic logic st_transient(line_st_e s);
    return (s >= LS_FILL1);
  endfunction

  function automatic logic st_fill_read(line_st_e s);
    return (s == LS_FILL1) || (s == LS_FILLN);
  endfunction

endpackage

// File: rtl/l2c_evdec.sv
module l2c_evdec
  import l2c_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int IDW = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  logic              ev_valid,
  input  logic [3:0]        ev_kind,
  input  logic [IDW-1:0]    ev_src,
  input  logic [NUM_L1-1:0] cur_shr,
  input  logic [IDW-1:0]    cur_own,
  output ev_flags_t         flags,
  output logic [NUM_L1-1:0] src_mask,
  output logic [NUM_L1-1:0] others_mask,
  output logic              src_is_owner
);

  function automatic logic [NUM_L1-1:0] id_bit(input logic [IDW-1:0] id);
    logic [NUM_L1-1:0] m;
    m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  logic     src_shares;
  ev_kind_e kind;

  assign kind         = ev_kind_e'(ev_kind);
  assign src_mask     = id_bit(ev_src);
  assign src_shares   = |(cur_shr & src_mask);
  assign others_mask  = cur_shr & ~src_mask;
  assign src_is_owner = (ev_src == cur_own);

  always_comb begin
    flags = '0;
    if (ev_valid) begin
      case (kind)
        EV_READ:   flags.rd    = 1'b1;
        EV_IREAD:  flags.ird   = 1'b1;
        EV_WRITE:  flags.wr    = 1'b1;
        EV_UPGR: begin
          if (src_shares) flags.upg = 1'b1;
          else            flags.wr  = 1'b1;
        end
        EV_WBACK:  flags.wb    = 1'b1;
        EV_MDATA:  flags.mdata = 1'b1;
        EV_MACK:   flags.mack  = 1'b1;
        EV_LDATA:  flags.ldata = 1'b1;
        EV_UNBLK:  flags.unb   = 1'b1;
        EV_XUNBLK: flags.xunb  = 1'b1;
        EV_REPL:   flags.repl  = 1'b1;
        EV_MINV:   flags.minv  = 1'b1;
        default:   flags       = '0;
      endcase
    end
  end

endmodule

// File: rtl/l2c_fsm_next.sv
module l2c_fsm_next
  import l2c_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int IDW = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  line_st_e          cur_st,
  input  ev_flags_t         f,
  input  logic [NUM_L1-1:0] cur_shr,
  input  logic [NUM_L1-1:0] cur_rd,
  input  logic [IDW-1:0]    cur_own,
  input  logic [IDW-1:0]    cur_wr,
  input  logic              cur_dirty,
  input  logic [IDW-1:0]    ev_src,
  input  logic              ev_dirty,
  input  logic [NUM_L1-1:0] src_mask,
  input  logic [NUM_L1-1:0] others_mask,
  input  logic              src_is_owner,
  output line_st_e          nxt_st,
  output logic [NUM_L1-1:0] nxt_shr,
  output logic [NUM_L1-1:0] nxt_rd,
  output logic [IDW-1:0]    nxt_own,
  output logic [IDW-1:0]    nxt_wr,
  output logic              nxt_dirty,
  output strobe_t           stb,
  output logic [NUM_L1-1:0] inv_mask,
  output logic [NUM_L1-1:0] data_mask,
  output logic [IDW-1:0]    fwd_dst
);

  function automatic logic [NUM_L1-1:0] id_bit(input logic [IDW-1:0] id);
    logic [NUM_L1-1:0] m;
    m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  logic reading, writing, demand, stall_class, merge_read, has_others;

  assign reading     = f.rd | f.ird;
  assign writing     = f.wr | f.upg;
  assign demand      = reading | writing;
  assign has_others  = |others_mask;
  assign merge_read  = reading & st_fill_read(cur_st);
  assign stall_class = st_transient(cur_st) & ~merge_read &
                       (demand | f.repl | (f.minv & (cur_st != LS_EVICT)));

  always_comb begin
    nxt_st    = cur_st;
    nxt_shr   = cur_shr;
    nxt_rd    = cur_rd;
    nxt_own   = cur_own;
    nxt_wr    = cur_wr;
    nxt_dirty = cur_dirty;
    stb       = '0;
    inv_mask  = '0;
    data_mask = '0;
    fwd_dst   = '0;
    stb.wback_ack = f.wb;

    if (stall_class) begin
      stb.recycle = 1'b1;
    end else if (merge_read) begin
      nxt_rd  = cur_rd | src_mask;
      nxt_shr = cur_shr | src_mask;
      nxt_st  = LS_FILLN;
    end else begin
      case (cur_st)
        LS_IDLE: begin
          if (reading) begin
            stb.fetch = 1'b1;
            nxt_shr   = src_mask;
            nxt_rd    = src_mask;
            nxt_st    = f.rd ? LS_FILL1 : LS_FILLN;
          end else if (writing) begin
            stb.fetch = 1'b1;
            nxt_shr   = '0;
            nxt_wr    = ev_src;
            nxt_st    = LS_FILLW;
          end
        end
        LS_SHR: begin
          if (reading) begin
            stb.data  = 1'b1;
            data_mask = src_mask;
            nxt_shr   = cur_shr | src_mask;
          end else if (writing) begin
            stb.inv  = has_others;
            inv_mask = has_others ? others_mask : '0;
            if (f.upg) begin
              stb.ack = 1'b1;
            end else begin
              stb.data  = 1'b1;
              stb.excl  = 1'b1;
              data_mask = src_mask;
            end
            nxt_st = LS_WAITX;
          end
        end
        LS_MOD: begin
          if (f.ird) begin
            stb.data  = 1'b1;
            data_mask = src_mask;
            nxt_shr   = src_mask;
            nxt_st    = LS_SHR;
          end else if (f.rd || writing) begin
            stb.data  = 1'b1;
            stb.excl  = 1'b1;
            data_mask = src_mask;
            nxt_st    = LS_WAITX;
          end else if (f.repl) begin
            stb.mem_data = cur_dirty;
            stb.mem_ack  = ~cur_dirty;
            nxt_st       = LS_EVICT;
          end
        end
        LS_L1OWN: begin
          if (demand) begin
            stb.fwd = 1'b1;
            fwd_dst = cur_own;
            nxt_st  = reading ? LS_FWD2 : LS_WAITX;
          end else if (f.wb && src_is_owner) begin
            nxt_shr   = '0;
            nxt_dirty = ev_dirty;
            nxt_st    = LS_MOD;
          end
        end
        LS_FILL1, LS_FILLN: begin
          if (f.mdata) begin
            stb.data  = 1'b1;
            stb.excl  = (cur_st == LS_FILL1);
            data_mask = cur_rd;
            nxt_st    = (cur_st == LS_FILL1) ? LS_WAITX : LS_SHR;
          end
        end
        LS_FILLW: begin
          if (f.mdata) begin
            stb.data  = 1'b1;
            stb.excl  = 1'b1;
            data_mask = id_bit(cur_wr);
            nxt_st    = LS_WAITX;
          end
        end
        LS_WAITX: begin
          if (f.xunb) begin
            nxt_shr = src_mask;
            nxt_own = ev_src;
            nxt_st  = LS_L1OWN;
          end
        end
        LS_FWD2: begin
          if (f.unb) begin
            nxt_shr = cur_shr | src_mask;
            nxt_st  = LS_FWDD;
          end else if (f.ldata) begin
            nxt_st = LS_FWDU;
          end
        end
        LS_FWDD: begin
          if (f.ldata) nxt_st = LS_SHR;
        end
        LS_FWDU: begin
          if (f.unb) begin
            nxt_shr = cur_shr | src_mask;
            nxt_st  = LS_SHR;
          end
        end
        LS_EVICT: begin
          if (f.mack) begin
            nxt_shr   = '0;
            nxt_rd    = '0;
            nxt_dirty = 1'b0;
            nxt_st    = LS_IDLE;
          end
        end
        default: nxt_st = LS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/l2c_line_regs.sv
module l2c_line_regs
  import l2c_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int IDW = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_st_e          nxt_st,
  input  logic [NUM_L1-1:0] nxt_shr,
  input  logic [NUM_L1-1:0] nxt_rd,
  input  logic [IDW-1:0]    nxt_own,
  input  logic [IDW-1:0]    nxt_wr,
  input  logic              nxt_dirty,
  output line_st_e          cur_st,
  output logic [NUM_L1-1:0] cur_shr,
  output logic [NUM_L1-1:0] cur_rd,
  output logic [IDW-1:0]    cur_own,
  output logic [IDW-1:0]    cur_wr,
  output logic              cur_dirty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_st    <= LS_IDLE;
      cur_shr   <= '0;
      cur_rd    <= '0;
      cur_own   <= '0;
      cur_wr    <= '0;
      cur_dirty <= 1'b0;
    end else begin
      cur_st    <= nxt_st;
      cur_shr   <= nxt_shr;
      cur_rd    <= nxt_rd;
      cur_own   <= nxt_own;
      cur_wr    <= nxt_wr;
      cur_dirty <= nxt_dirty;
    end
  end

endmodule

// File: rtl/l2_line_ctrl.sv
module l2_line_ctrl
  import l2c_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int IDW = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [3:0]        ev_kind,
  input  logic [IDW-1:0]    ev_src,
  input  logic              ev_dirty,
  output logic              recycle,
  output logic              send_fetch,
  output logic              send_fwd,
  output logic [IDW-1:0]    fwd_dst,
  output logic              send_inv,
  output logic [NUM_L1-1:0] inv_mask,
  output logic              send_data,
  output logic [NUM_L1-1:0] data_mask,
  output logic              data_excl,
  output logic              send_ack,
  output logic              send_wback_ack,
  output logic              send_mem_data,
  output logic              send_mem_ack,
  output logic [3:0]        line_state,
  output logic [NUM_L1-1:0] sharers,
  output logic [IDW-1:0]    owner
);

  ev_flags_t         flags;
  strobe_t           stb;
  line_st_e          cur_st, nxt_st;
  logic [NUM_L1-1:0] cur_shr, nxt_shr, cur_rd, nxt_rd, src_mask, others_mask;
  logic [IDW-1:0]    cur_own, nxt_own, cur_wr, nxt_wr;
  logic              cur_dirty, nxt_dirty, src_is_owner;

  // named internal events used by the checker
  logic grant_owned, evict_done;
  assign grant_owned = (cur_st == LS_WAITX) && flags.xunb;
  assign evict_done  = (cur_st == LS_EVICT) && flags.mack;

  l2c_evdec #(.NUM_L1(NUM_L1), .IDW(IDW)) u_dec (
    .ev_valid     (ev_valid),
    .ev_kind      (ev_kind),
    .ev_src       (ev_src),
    .cur_shr      (cur_shr),
    .cur_own      (cur_own),
    .flags        (flags),
    .src_mask     (src_mask),
    .others_mask  (others_mask),
    .src_is_owner (src_is_owner)
  );

  l2c_fsm_next #(.NUM_L1(NUM_L1), .IDW(IDW)) u_nxt (
    .cur_st       (cur_st),
    .f            (flags),
    .cur_shr      (cur_shr),
    .cur_rd       (cur_rd),
    .cur_own      (cur_own),
    .cur_wr       (cur_wr),
    .cur_dirty    (cur_dirty),
    .ev_src       (ev_src),
    .ev_dirty     (ev_dirty),
    .src_mask     (src_mask),
    .others_mask  (others_mask),
    .src_is_owner (src_is_owner),
    .nxt_st       (nxt_st),
    .nxt_shr      (nxt_shr),
    .nxt_rd       (nxt_rd),
    .nxt_own      (nxt_own),
    .nxt_wr       (nxt_wr),
    .nxt_dirty    (nxt_dirty),
    .stb          (stb),
    .inv_mask     (inv_mask),
    .data_mask    (data_mask),
    .fwd_dst      (fwd_dst)
  );

  l2c_line_regs #(.NUM_L1(NUM_L1), .IDW(IDW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_st    (nxt_st),
    .nxt_shr   (nxt_shr),
    .nxt_rd    (nxt_rd),
    .nxt_own   (nxt_own),
    .nxt_wr    (nxt_wr),
    .nxt_dirty (nxt_dirty),
    .cur_st    (cur_st),
    .cur_shr   (cur_shr),
    .cur_rd    (cur_rd),
    .cur_own   (cur_own),
    .cur_wr    (cur_wr),
    .cur_dirty (cur_dirty)
  );

  assign recycle        = stb.recycle;
  assign send_fetch     = stb.fetch;
  assign send_fwd       = stb.fwd;
  assign send_inv       = stb.inv;
  assign send_data      = stb.data;
  assign data_excl      = stb.excl;
  assign send_ack       = stb.ack;
  assign send_wback_ack = stb.wback_ack;
  assign send_mem_data  = stb.mem_data;
  assign send_mem_ack   = stb.mem_ack;
  assign line_state     = cur_st;
  assign sharers        = cur_shr;
  assign owner          = cur_own;

endmodule

// File: rtl/l2c_checker.sv
module l2c_checker
  import l2c_pkg::*;
#(
  parameter int NUM_L1 = 4,
  parameter int IDW = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [3:0]        ev_kind,
  input logic [IDW-1:0]    ev_src,
  input logic              recycle,
  input logic              send_fetch,
  input logic              send_fwd,
  input logic              send_inv,
  input logic [NUM_L1-1:0] inv_mask,
  input logic              send_data,
  input logic              send_ack,
  input logic              send_wback_ack,
  input logic              send_mem_data,
  input logic              send_mem_ack,
  input logic [3:0]        line_state,
  input logic [NUM_L1-1:0] sharers,
  input logic [IDW-1:0]    owner,
  input logic              grant_owned,
  input logic              evict_done
);

  logic any_out;
  assign any_out = recycle | send_fetch | send_fwd | send_inv | send_data |
                   send_ack | send_wback_ack | send_mem_data | send_mem_ack;

  AST_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> !any_out);  // R1

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(line_state) && $stable(sharers));  // R1

  AST_RECYCLE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    recycle |-> !(send_fetch | send_fwd | send_inv | send_data | send_ack |
                  send_mem_data | send_mem_ack));  // R9

  AST_RECYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    recycle |=> $stable(line_state) && $stable(sharers));  // R9

  AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    send_inv |-> (inv_mask != '0) && !inv_mask[ev_src]);  // R6

  AST_OWNED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 4'd3) |-> ($countones(sharers) == 1) && sharers[owner]);  // R7

  AST_GRANT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    grant_owned |=> (line_state == 4'd3) && (owner == $past(ev_src)));  // R7

  AST_EVICT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evict_done |=> (line_state == 4'd0) && (sharers == '0));  // R11

  AST_WBACK_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == 4'd4) |-> send_wback_ack);  // R10

  AST_FETCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    send_fetch |-> (line_state == 4'd0));  // R3

endmodule

bind l2_line_ctrl l2c_checker #(.NUM_L1(NUM_L1), .IDW(IDW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_valid       (ev_valid),
  .ev_kind        (ev_kind),
  .ev_src         (ev_src),
  .recycle        (recycle),
  .send_fetch     (send_fetch),
  .send_fwd       (send_fwd),
  .send_inv       (send_inv),
  .inv_mask       (inv_mask),
  .send_data      (send_data),
  .send_ack       (send_ack),
  .send_wback_ack (send_wback_ack),
  .send_mem_data  (send_mem_data),
  .send_mem_ack   (send_mem_ack),
  .line_state     (line_state),
  .sharers        (sharers),
  .owner          (owner),
  .grant_owned    (grant_owned),
  .evict_done     (evict_done)
);

// File: tb/sim_l2_line_ctrl.sv
module sim_l2_line_ctrl;

  localparam int N   = 4;
  localparam int IDW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ev_valid = 1'b0;
  logic [3:0]     ev_kind = '0;
  logic [IDW-1:0] ev_src = '0;
  logic           ev_dirty = 1'b0;
  logic           recycle, send_fetch, send_fwd, send_inv, send_data, data_excl;
  logic           send_ack, send_wback_ack, send_mem_data, send_mem_ack;
  logic [IDW-1:0] fwd_dst, owner;
  logic [N-1:0]   inv_mask, data_mask, sharers;
  logic [3:0]     line_state;

  always #10 clk = ~clk;  // 50 MHz

  l2_line_ctrl #(.NUM_L1(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_src(ev_src), .ev_dirty(ev_dirty), .recycle(recycle),
    .send_fetch(send_fetch), .send_fwd(send_fwd), .fwd_dst(fwd_dst),
    .send_inv(send_inv), .inv_mask(inv_mask), .send_data(send_data),
    .data_mask(data_mask), .data_excl(data_excl), .send_ack(send_ack),
    .send_wback_ack(send_wback_ack), .send_mem_data(send_mem_data),
    .send_mem_ack(send_mem_ack), .line_state(line_state),
    .sharers(sharers), .owner(owner)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int       ms = 0;
  bit [3:0] msh = '0;
  bit [3:0] mrd = '0;
  int       mown = 0;
  int       mwr = 0;
  bit       mdirty = 1'b0;

  // expected outputs
  bit       e_rec, e_fet, e_fwd, e_inv, e_dat, e_exc, e_ack, e_wba, e_md, e_ma;
  bit [3:0] e_invm, e_datm;

  task automatic model(input bit v, input int k, input int s, input bit d);
    bit [3:0] me;
    bit rd, wrt, upg, dem;
    {e_rec, e_fet, e_fwd, e_inv, e_dat, e_exc, e_ack, e_wba, e_md, e_ma} = '0;
    e_invm = '0;
    e_datm = '0;
    if (!v) return;
    me = '0;
    me[s] = 1'b1;
    rd  = (k == 0) || (k == 1);
    upg = (k == 3) && msh[s];
    wrt = (k == 2) || ((k == 3) && !msh[s]);
    dem = (k >= 0) && (k <= 3);
    e_wba = (k == 4);
    if (ms >= 4) begin
      if ((ms == 4 || ms == 5) && rd) begin
        mrd = mrd | me; msh = msh | me; ms = 5;
      end else if (ms == 11 && k == 11) begin
        // dropped
      end else if (dem || k == 10 || k == 11) begin
        e_rec = 1'b1;
      end else if (ms == 4 && k == 5) begin
        e_dat = 1; e_datm = mrd; e_exc = 1; ms = 7;
      end else if (ms == 5 && k == 5) begin
        e_dat = 1; e_datm = mrd; ms = 1;
      end else if (ms == 6 && k == 5) begin
        e_dat = 1; e_exc = 1; e_datm = '0; e_datm[mwr] = 1'b1; ms = 7;
      end else if (ms == 7 && k == 9) begin
        msh = me; mown = s; ms = 3;
      end else if (ms == 8 && k == 8) begin
        msh = msh | me; ms = 9;
      end else if (ms == 8 && k == 7) begin
        ms = 10;
      end else if (ms == 9 && k == 7) begin
        ms = 1;
      end else if (ms == 10 && k == 8) begin
        msh = msh | me; ms = 1;
      end else if (ms == 11 && k == 6) begin
        ms = 0; msh = '0; mrd = '0; mdirty = 0;
      end
    end else if (ms == 0) begin
      if (rd) begin
        e_fet = 1; msh = me; mrd = me; ms = (k == 0) ? 4 : 5;
      end else if (wrt) begin
        e_fet = 1; msh = '0; mwr = s; ms = 6;
      end
    end else if (ms == 1) begin
      if (rd) begin
        e_dat = 1; e_datm = me; msh = msh | me;
      end else if (wrt || upg) begin
        e_invm = msh & ~me;
        e_inv = (e_invm != 0);
        if (upg) e_ack = 1;
        else begin e_dat = 1; e_exc = 1; e_datm = me; end
        ms = 7;
      end
    end else if (ms == 2) begin
      if (k == 1) begin
        e_dat = 1; e_datm = me; msh = me; ms = 1;
      end else if (k == 0 || wrt || upg) begin
        e_dat = 1; e_exc = 1; e_datm = me; ms = 7;
      end else if (k == 10) begin
        e_md = mdirty; e_ma = !mdirty; ms = 11;
      end
    end else begin  // ms == 3
      if (dem) begin
        e_fwd = 1; ms = rd ? 8 : 7;
      end else if (k == 4 && s == mown) begin
        msh = '0; mdirty = d; ms = 2;
      end
    end
  endtask

  task automatic step(input string tag, input bit v, input int k, input int s, input bit d);
    logic [35:0] act, exp_v;
    logic [IDW-1:0] e_dst, e_own;
    logic [3:0] e_st, e_sh;
    @(negedge clk);
    ev_valid = v;
    ev_kind  = 4'(k);
    ev_src   = IDW'(s);
    ev_dirty = d;
    #2;
    e_st  = 4'(ms);
    e_sh  = msh;
    e_own = IDW'(mown);
    model(v, k, s, d);
    e_dst = e_fwd ? IDW'(mown) : '0;
    act = {recycle, send_fetch, send_fwd, fwd_dst, send_inv, inv_mask, send_data,
           data_mask, data_excl, send_ack, send_wback_ack, send_mem_data,
           send_mem_ack, line_state, sharers, owner};
    exp_v = {e_rec, e_fet, e_fwd, e_dst, e_inv, e_invm, e_dat, e_datm, e_exc,
             e_ack, e_wba, e_md, e_ma, e_st, e_sh, e_own};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (kind %0d src %0d)", tag, act, exp_v, k, s);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0);
    step("R2", 1, 13, 2, 0);
    // single-reader fill, forwarding with unblock after data
    step("R3", 1, 0, 1, 0);
    step("R9", 1, 2, 2, 0);
    step("R3", 1, 5, 0, 0);
    step("R9", 1, 0, 3, 0);
    step("R1", 0, 0, 0, 0);
    step("R7", 1, 9, 1, 0);
    step("R13", 1, 10, 0, 0);
    step("R8", 1, 0, 2, 0);
    step("R8", 1, 7, 1, 1);
    step("R8", 1, 8, 2, 0);
    step("R6", 1, 2, 3, 0);
    step("R7", 1, 9, 3, 0);
    step("R10", 1, 4, 0, 1);
    step("R10", 1, 4, 3, 1);
    step("R11", 1, 10, 0, 0);
    step("R9", 1, 0, 0, 0);
    step("R9", 1, 11, 0, 0);
    step("R11", 1, 6, 0, 0);
    // multi-reader fill, upgrade, forwarding with unblock first
    step("R4", 1, 1, 0, 0);
    step("R4", 1, 0, 2, 0);
    step("R4", 1, 5, 0, 0);
    step("R13", 1, 11, 1, 0);
    step("R6", 1, 1, 1, 0);
    step("R6", 1, 3, 2, 0);
    step("R7", 1, 9, 2, 0);
    step("R8", 1, 1, 1, 0);
    step("R8", 1, 8, 1, 0);
    step("R8", 1, 7, 2, 0);
    step("R5", 1, 3, 3, 0);
    step("R7", 1, 9, 3, 0);
    step("R10", 1, 4, 3, 0);
    step("R12", 1, 1, 2, 0);
    step("R6", 1, 3, 2, 0);
    step("R7", 1, 9, 2, 0);
    step("R10", 1, 4, 2, 0);
    step("R12", 1, 0, 1, 0);
    step("R7", 1, 9, 1, 0);
    step("R8", 1, 2, 0, 0);
    step("R7", 1, 9, 0, 0);
    step("R10", 1, 4, 0, 0);
    step("R11", 1, 10, 0, 0);
    step("R11", 1, 6, 0, 0);
    // second read merges into a single-reader fill
    step("R4", 1, 0, 1, 0);
    step("R4", 1, 0, 0, 0);
    step("R4", 1, 5, 0, 0);
    step("R13", 1, 5, 0, 0);
    step("R6", 1, 3, 1, 0);
    step("R7", 1, 9, 1, 0);
    step("R10", 1, 4, 1, 0);
    step("R11", 1, 10, 0, 0);
    step("R11", 1, 6, 0, 0);
    // writer fill
    step("R5", 1, 2, 3, 0);
    step("R9", 1, 0, 0, 0);
    step("R9", 1, 10, 0, 0);
    step("R5", 1, 5, 0, 0);
    step("R7", 1, 9, 3, 0);
    step("R8", 1, 2, 1, 0);
    step("R7", 1, 9, 1, 0);
    step("R1", 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule